// File: doc/BRIEF.md
# Two-Wire Bus Target Controller

This block is the target (slave) side of an I2C bus. It watches the open-drain clock and data lines from a fast system clock and finds START and STOP conditions. It collects the address byte and answers only when the 7-bit address equals the `own_addr` input. It never drives a line high. It owns one output, `sda_pull`, which the pad turns into a pull-down on the data line. The block never holds the clock low.

For a write, the controller sends bytes. Each byte is acknowledged and then shown on `rx_data` with a one-cycle `rx_strobe`. For a read, user logic puts a byte on `tx_data` with a `tx_valid` pulse. The block holds that byte in a single-entry register until the bus needs it, then shifts it out MSB first. `rd_dir` shows the direction of the current transaction. `dev_busy` marks this target as addressed. `bus_busy` marks any traffic between START and STOP, including traffic to other devices. `nack_err` is raised when the controller refuses a byte this target sent.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `sda_pull`, `rx_strobe`, `dev_busy`, `bus_busy`, `nack_err` and `rd_dir` are all 0.
- R2: A START (data falling while clock is high) sets `bus_busy`. A STOP (data rising while clock is high) clears both `bus_busy` and `dev_busy` within four system clocks of the data pin rising.
- R3: The first byte after START is seven address bits, MSB first, followed by the direction bit. The target pulls data low through the ninth clock only when the address equals `own_addr`. On a mismatch it never pulls data for the rest of the transaction, produces no `rx_strobe`, and keeps `dev_busy` low while `bus_busy` stays high.
- R4: After a matching address, `dev_busy` is 1 and `rd_dir` equals the direction bit (1 = read, 0 = write).
- R5: In a write, every data byte is acknowledged by pulling data low through its ninth clock. The byte, assembled MSB first, then appears on `rx_data` with a one-cycle `rx_strobe`. `rx_data` changes only together with `rx_strobe`.
- R6: In a read, the byte last given with `tx_valid` is shifted out MSB first. The target pulls data low for 0 bits and releases it for 1 bits. The next byte is loaded when the acknowledge clock ends. If no new byte was given, the target sends all ones and so keeps the line released.
- R7: If data is high at the rising clock of the acknowledge slot after a byte the target sent, `nack_err` becomes 1. The target then releases data until the next START or STOP. The next START clears `nack_err`.
- R8: A repeated START without a STOP restarts address decoding, so one bus ownership can move from a write to a read.
- R9: The target never pulls data while `bus_busy` is 0, and `dev_busy` implies `bus_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sensed bus clock line |
| sda_in | input | 1 | Sensed bus data line |
| own_addr | input | ADDR_W | Address this target answers to |
| tx_data | input | DATA_W | Byte to send on reads |
| tx_valid | input | 1 | Loads `tx_data` into the holding register |
| sda_pull | output | 1 | 1 = pull the data line low |
| rx_data | output | DATA_W | Last byte received in a write |
| rx_strobe | output | 1 | One-cycle pulse when `rx_data` is new |
| rd_dir | output | 1 | Direction bit of the current transaction |
| dev_busy | output | 1 | This target is addressed |
| bus_busy | output | 1 | Bus is between START and STOP |
| nack_err | output | 1 | Controller refused a byte sent by the target |

## Verification
The properties assume a bus that follows the protocol. Data changes only while the clock is low, except at START and STOP. Each clock phase lasts well beyond the synchronizer depth, so every edge is seen once and in order. The stimulus keeps each clock quarter at eight system clocks and drives the pins only on the falling system-clock edge. Before a STOP that follows a read, it makes sure no transmit byte is pending, so the target has released the data line. Under these conditions the properties check three things: pull-downs only during bus activity, the pairing of `rx_data` changes with `rx_strobe`, and the ordering of the busy flags.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK,
      ST_SKIP
   } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("i2c_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_tgt_linemon.sv
module i2c_tgt_linemon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c,
   output logic sda_now
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_c  = scl & scl_q & sda_q & ~sda;
   assign stop_c   = scl & scl_q & ~sda_q & sda;
   assign sda_now  = sda;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              sda_pull,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_strobe,
   output logic              rd_dir,
   output logic              dev_busy,
   output logic              bus_busy,
   output logic              nack_err
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
   localparam logic [DATA_W-1:0] IDLE_FILL = '1;

   generate
      if (ADDR_W + 1 != DATA_W) begin : g_bad_w
         $error("i2c_target_ctrl: address plus direction bit must fill one byte");
      end
   endgenerate

   logic [1:0] sync_q;
   logic scl_rise, scl_fall, start_c, stop_c, sda_now;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(sync_q)
   );

   i2c_tgt_linemon u_mon (
      .clk(clk), .rst_n(rst_n), .scl(sync_q[1]), .sda(sync_q[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c), .sda_now(sda_now)
   );

   tgt_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sh, tx_sh, tx_hold;
   logic              hold_full;
   logic [DATA_W-1:0] next_tx;

   assign next_tx = hold_full ? tx_hold : IDLE_FILL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         tx_hold   <= '0;
         hold_full <= 1'b0;
         sda_pull  <= 1'b0;
         rx_data   <= '0;
         rx_strobe <= 1'b0;
         rd_dir    <= 1'b0;
         dev_busy  <= 1'b0;
         bus_busy  <= 1'b0;
         nack_err  <= 1'b0;
      end else begin
         rx_strobe <= 1'b0;
         if (tx_valid) begin
            tx_hold   <= tx_data;
            hold_full <= 1'b1;
         end
         if (stop_c) begin
            state    <= ST_IDLE;
            bus_busy <= 1'b0;
            dev_busy <= 1'b0;
            sda_pull <= 1'b0;
         end else if (start_c) begin
            state    <= ST_ADDR;
            bus_busy <= 1'b1;
            dev_busy <= 1'b0;
            nack_err <= 1'b0;
            sda_pull <= 1'b0;
            cnt      <= '0;
         end else begin
            unique case (state)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     rx_sh <= {rx_sh[DATA_W-2:0], sda_now};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     if (state == ST_RX) begin
                        rx_data   <= rx_sh;
                        rx_strobe <= 1'b1;
                        sda_pull  <= 1'b1;
                        state     <= ST_RACK;
                     end else if (rx_sh[DATA_W-1:1] == own_addr) begin
                        sda_pull <= 1'b1;
                        dev_busy <= 1'b1;
                        rd_dir   <= rx_sh[0];
                        state    <= ST_AACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK, ST_TACK: begin
                  if (state == ST_TACK && scl_rise && sda_now) begin
                     nack_err <= 1'b1;
                     state    <= ST_SKIP;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (state == ST_TACK || rd_dir) begin
                        tx_sh     <= next_tx;
                        sda_pull  <= ~next_tx[DATA_W-1];
                        hold_full <= tx_valid;
                        state     <= ST_TX;
                     end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_RX;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     cnt      <= '0;
                     state    <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_pull <= 1'b0;
                        state    <= ST_TACK;
                     end else begin
                        sda_pull <= ~tx_sh[DATA_W-2];
                        tx_sh    <= {tx_sh[DATA_W-2:0], 1'b1};
                     end
                  end
               end
               default: sda_pull <= 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_target_ctrl_chk.sv
module i2c_target_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_pull,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_strobe,
   input logic              rd_dir,
   input logic              dev_busy,
   input logic              bus_busy,
   input logic              nack_err
);
   AST_NO_PULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy |-> !sda_pull);                                     // R9
   AST_DEV_IN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      dev_busy |-> bus_busy);                                       // R9
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);                                    // R5
   AST_RXDATA_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> rx_strobe);                             // R5
   AST_STROBE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> (dev_busy && !rd_dir));                         // R5
   AST_NACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack_err) |-> (rd_dir && dev_busy));                    // R7
   AST_STOP_DROPS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_busy) |-> !dev_busy);                               // R2
endmodule

bind i2c_target_ctrl i2c_target_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .rx_data(rx_data),
   .rx_strobe(rx_strobe), .rd_dir(rd_dir), .dev_busy(dev_busy),
   .bus_busy(bus_busy), .nack_err(nack_err)
);

// File: tb/i2c_target_ctrl_test.sv
module i2c_target_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic [6:0] own_addr = 7'h60;
   logic [7:0] tx_data = 8'h00;
   logic tx_valid = 1'b0;
   logic sda_pull, rx_strobe, rd_dir, dev_busy, bus_busy, nack_err;
   logic [7:0] rx_data;
   logic sda_in;
   int vectors = 0, miscompares = 0, strobes = 0;
   logic [7:0] exp_q[$];

   always #10 clk = ~clk;
   assign sda_in = m_sda & ~sda_pull;

   i2c_target_ctrl uut (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_in),
      .own_addr(own_addr), .tx_data(tx_data), .tx_valid(tx_valid),
      .sda_pull(sda_pull), .rx_data(rx_data), .rx_strobe(rx_strobe),
      .rd_dir(rd_dir), .dev_busy(dev_busy), .bus_busy(bus_busy),
      .nack_err(nack_err)
   );

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // scoreboard monitor: written bytes (R5); unaddressed strobes fail (R3)
   always @(negedge clk) if (rst_n && rx_strobe) begin
      strobes++;
      if (exp_q.size() == 0) check("R3 unexpected rx_strobe", 1, 0);
      else check("R5 rx_data", rx_data, exp_q.pop_front());
   end

   task automatic qtr(); repeat (8) @(negedge clk); endtask

   task automatic bus_start();
      m_sda = 1'b1; qtr(); m_scl = 1'b1; qtr(); m_sda = 1'b0; qtr(); m_scl = 1'b0; qtr();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qtr(); m_scl = 1'b1; qtr(); m_sda = 1'b1;
      repeat (4) @(negedge clk);
      check("R2 bus_busy after stop", bus_busy, 0);
      check("R2 dev_busy after stop", dev_busy, 0);
      qtr();
   endtask

   task automatic write_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qtr(); m_scl = 1'b1; qtr(); qtr(); m_scl = 1'b0; qtr();
      end
      m_sda = 1'b1; qtr(); m_scl = 1'b1; qtr();
      acked = ~sda_in;
      qtr(); m_scl = 1'b0; qtr();
   endtask

   task automatic read_byte(input logic ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qtr(); m_scl = 1'b1; qtr(); b[i] = sda_in; qtr(); m_scl = 1'b0;
      end
      qtr(); m_sda = ~ack; qtr(); m_scl = 1'b1; qtr(); qtr(); m_scl = 1'b0; qtr();
      m_sda = 1'b1;
   endtask

   task automatic give_tx(input logic [7:0] b);
      @(negedge clk); tx_data = b; tx_valid = 1'b1;
      @(negedge clk); tx_valid = 1'b0;
   endtask

   task automatic send_data(input logic [7:0] b, output logic acked);
      exp_q.push_back(b);
      write_byte(b, acked);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check("watchdog expired", 1, 0);
      summary();
   end

   initial begin
      logic ack;
      logic [7:0] rd;
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 sda_pull", sda_pull, 0);
      check("R1 bus_busy", bus_busy, 0);
      check("R1 dev_busy", dev_busy, 0);
      check("R1 nack_err", nack_err, 0);
      check("R1 rx_strobe", rx_strobe, 0);
      check("R1 rd_dir", rd_dir, 0);
      rst_n = 1'b1;
      qtr();
      check("R9 line released idle", sda_in, 1);

      // write transaction
      own_addr = 7'h60;
      bus_start();
      check("R2 bus_busy after start", bus_busy, 1);
      write_byte({7'h60, 1'b0}, ack);
      check("R3 address ack", ack, 1);
      check("R4 dev_busy", dev_busy, 1);
      check("R4 rd_dir write", rd_dir, 0);
      send_data(8'hD4, ack);
      check("R5 data ack 1", ack, 1);
      send_data(8'h33, ack);
      check("R5 data ack 2", ack, 1);
      bus_stop();

      // read transaction, two bytes then idle fill
      own_addr = 7'h61;
      give_tx(8'hD4);
      bus_start();
      write_byte({7'h61, 1'b1}, ack);
      check("R3 read address ack", ack, 1);
      check("R4 rd_dir read", rd_dir, 1);
      give_tx(8'h35);
      read_byte(1'b1, rd);
      check("R6 read byte 1", rd, 8'hD4);
      read_byte(1'b1, rd);
      check("R6 read byte 2", rd, 8'h35);
      check("R7 no error when acked", nack_err, 0);
      read_byte(1'b1, rd);
      check("R6 empty holding sends ones", rd, 8'hFF);
      bus_stop();

      // address mismatch
      own_addr = 7'h78;
      bus_start();
      write_byte({7'h60, 1'b0}, ack);
      check("R3 mismatch no ack", ack, 0);
      check("R3 mismatch dev_busy", dev_busy, 0);
      check("R3 mismatch bus_busy", bus_busy, 1);
      write_byte(8'hA5, ack);
      check("R3 mismatch data not acked", ack, 0);
      bus_stop();

      // controller refuses a read byte
      own_addr = 7'h61;
      give_tx(8'h5A);
      bus_start();
      write_byte({7'h61, 1'b1}, ack);
      check("R7 address ack", ack, 1);
      give_tx(8'h00);
      read_byte(1'b0, rd);
      check("R6 read byte before refusal", rd, 8'h5A);
      check("R7 nack_err set", nack_err, 1);
      read_byte(1'b0, rd);
      check("R7 released after refusal", rd, 8'hFF);
      bus_start();
      check("R7 start clears nack_err", nack_err, 0);
      write_byte({7'h61, 1'b0}, ack);
      check("R7 new address ack", ack, 1);
      bus_stop();

      // write, repeated start, read (R8)
      own_addr = 7'h60;
      bus_start();
      write_byte({7'h60, 1'b0}, ack);
      send_data(8'h96, ack);
      check("R8 write before restart acked", ack, 1);
      give_tx(8'h0F);
      bus_start();
      check("R8 bus stays busy", bus_busy, 1);
      write_byte({7'h60, 1'b1}, ack);
      check("R8 restart address ack", ack, 1);
      check("R8 direction now read", rd_dir, 1);
      check("R8 dev_busy", dev_busy, 1);
      read_byte(1'b1, rd);
      check("R8 read after restart", rd, 8'h0F);
      bus_stop();
      check("R9 line released after stop", sda_in, 1);

      check("R5 scoreboard drained", exp_q.size(), 0);
      check("R5 strobe count", strobes, 3);
      summary();
   end
endmodule